// File: doc/BRIEF.md
# Vector Complex Multiply-Accumulate Engine

This block runs one of four complex vector operations over a stream of complex samples. Each sample is combined with a coefficient from a local store of 96 complex entries, and the result goes into two signed 32-bit accumulators, A0 for the real part and A1 for the imaginary part. The host reaches the coefficient store, the accumulators, a start-index register, a control register and a read-only status byte over a simple register bus. Writes take effect at the clock edge. Reads are combinational from the registered state.

To launch a run, the host writes the control register with the go bit set and a non-zero length. The engine then takes one sample in each cycle where `smp_valid` is high. It fetches coefficients in order from the programmed start index and wraps from the last entry back to entry 0. Accumulator overflow saturates the accumulator and sets sticky flags in the status byte. Certain host writes clear those flags.

Top module: `vcm_engine`

## Requirements
- R1: After reset, every accumulator, the status byte, the control and start-index registers, every coefficient entry and `busy` are zero.
- R2: Coefficient n is read and written at byte address 4*n (0x000 to 0x17C). A complex value holds a signed 16-bit real part in bits 15:0 and a signed 16-bit imaginary part in bits 31:16. With `host_dword`=1 a write replaces all 32 bits. With `host_dword`=0 it writes `host_wdata[15:0]` into the half chosen by address bit 1 (0 selects the low half, 1 the high half). A read always returns the full 32-bit entry.
- R3: Opcode 00 (multiply-add) adds the complex product x*c of each sample and coefficient to the current A0/A1 values: real x.re*c.re - x.im*c.im, imaginary x.re*c.im + x.im*c.re.
- R4: Opcode 01 (multiply) loads A0/A1 with the product of each element, so they hold the product of the last element when the run ends.
- R5: Opcode 10 (multiply-accumulate) clears A0 and A1 when the run starts, then adds each element's product.
- R6: Opcode 11 (magnitude) adds re*re + im*im of each sample to A0 and leaves A1 unchanged.
- R7: When an accumulator result falls outside the signed 32-bit range, the accumulator saturates to 0x7FFFFFFF or 0x80000000. The overflow also sets status bit 0 (for A0) or bit 1 (for A1).
- R8: Status (address 0x210) bit 7 is the OR of bits 0 and 1, and bits 6:2 read zero. The flags stay set through later elements and later runs until a clearing event occurs.
- R9: Any host write to A0 (0x208), A1 (0x20C) or the control register (0x200) clears the status byte to zero.
- R10: A run fetches coefficients from the start index (0x204, bits 6:0) upward and wraps from 95 to 0. A start value above 95 is stored as 0.
- R11: Control bits 1:0 hold the opcode, bits 14:8 the length and bit 31 is go (not stored). `busy` rises in the cycle after a go write with a non-zero length. It stays high while `smp_valid` is low and falls in the cycle after the last sample is taken. While a run is active, a control write changes neither opcode nor length and starts nothing; a zero length starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe |
| host_dword | input | 1 | 1: 32-bit write, 0: 16-bit write |
| host_addr | input | 10 | Host byte address |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Read data for `host_addr` |
| smp_valid | input | 1 | Sample present on `smp_data` |
| smp_data | input | 32 | Complex sample, real in 15:0, imaginary in 31:16 |
| busy | output | 1 | Vector run in progress |

## Verification
A wrong coefficient index, step counter or opcode stays hidden while samples flow. It becomes visible in the accumulator values the host reads after the run. A wrong `busy` fall shows up one cycle after the last sample, because the reference model tracks `busy` on every clock. Status flags that fail to stick or fail to clear show at the status address on the first read after the overflow or the clearing write. Reads are combinational, so each of these faults appears within the same cycle of the read.

// File: rtl/vcm_pkg.sv
package vcm_pkg;

    typedef enum logic [1:0] {
        VOP_MADD = 2'b00,
        VOP_MUL  = 2'b01,
        VOP_MAC  = 2'b10,
        VOP_MAG  = 2'b11
    } vop_e;

    typedef struct packed {
        logic [31:0] val;
        logic        ovf;
    } sat_t;

    // Clamp a wide signed sum into the signed 32-bit range.
    function automatic sat_t sat32(input logic signed [34:0] s);
        sat_t r;
        if (s > 35'sd2147483647) begin
            r.val = 32'h7FFF_FFFF;
            r.ovf = 1'b1;
        end else if (s < -35'sd2147483648) begin
            r.val = 32'h8000_0000;
            r.ovf = 1'b1;
        end else begin
            r.val = s[31:0];
            r.ovf = 1'b0;
        end
        return r;
    endfunction

endpackage

// File: rtl/vcm_cstore.sv
module vcm_cstore #(
    parameter  int NCOEF = 96,
    localparam int IDX_W = $clog2(NCOEF)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [1:0]       wmask,
    input  logic [IDX_W-1:0] widx,
    input  logic [31:0]      wdata,
    input  logic [IDX_W-1:0] eng_idx,
    output logic [31:0]      eng_data,
    input  logic [IDX_W-1:0] host_idx,
    output logic [31:0]      host_data
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(NCOEF - 1);

    logic [31:0] mem_q [NCOEF];
    logic [31:0] mem_d [NCOEF];

    always_comb begin
        for (int i = 0; i < NCOEF; i++) begin
            mem_d[i] = mem_q[i];
            if (we && widx == IDX_W'(i)) begin
                if (wmask[0]) mem_d[i][15:0]  = wdata[15:0];
                if (wmask[1]) mem_d[i][31:16] = wmask[0] ? wdata[31:16] : wdata[15:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < NCOEF; i++) begin
            if (!rst_n) mem_q[i] <= '0;
            else        mem_q[i] <= mem_d[i];
        end
    end

    assign eng_data  = (eng_idx  <= LAST) ? mem_q[eng_idx]  : '0;
    assign host_data = (host_idx <= LAST) ? mem_q[host_idx] : '0;

endmodule

// File: rtl/vcm_dp.sv
module vcm_dp
    import vcm_pkg::*;
(
    input  vop_e        op,
    input  logic [31:0] smp,
    input  logic [31:0] coef,
    input  logic [31:0] acc0,
    input  logic [31:0] acc1,
    output logic [31:0] nxt0,
    output logic [31:0] nxt1,
    output logic        ovf0,
    output logic        ovf1
);
    logic signed [15:0] xr, xi, cr, ci;
    logic signed [31:0] p_rr, p_ii, p_ri, p_ir, p_xx, p_yy;
    logic signed [33:0] t_re, t_im, t_mag, term0, term1;
    logic signed [31:0] base0, base1;
    logic signed [34:0] s0, s1;
    sat_t r0, r1;

    always_comb begin
        xr    = smp[15:0];
        xi    = smp[31:16];
        cr    = coef[15:0];
        ci    = coef[31:16];
        p_rr  = xr * cr;
        p_ii  = xi * ci;
        p_ri  = xr * ci;
        p_ir  = xi * cr;
        p_xx  = xr * xr;
        p_yy  = xi * xi;
        t_re  = 34'(p_rr) - 34'(p_ii);
        t_im  = 34'(p_ri) + 34'(p_ir);
        t_mag = 34'(p_xx) + 34'(p_yy);
        base0 = (op == VOP_MUL) ? 32'sd0 : acc0;
        base1 = (op == VOP_MUL) ? 32'sd0 : acc1;
        term0 = (op == VOP_MAG) ? t_mag : t_re;
        term1 = (op == VOP_MAG) ? 34'sd0 : t_im;
        s0    = 35'(base0) + 35'(term0);
        s1    = 35'(base1) + 35'(term1);
        r0    = sat32(s0);
        r1    = sat32(s1);
        nxt0  = r0.val;
        ovf0  = r0.ovf;
        nxt1  = r1.val;
        ovf1  = r1.ovf;
    end

endmodule

// File: rtl/vcm_engine.sv
module vcm_engine
    import vcm_pkg::*;
#(
    parameter  int NCOEF  = 96,
    localparam int IDX_W  = $clog2(NCOEF),
    localparam int ADDR_W = IDX_W + 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic              host_dword,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [31:0]       host_wdata,
    output logic [31:0]       host_rdata,
    input  logic              smp_valid,
    input  logic [31:0]       smp_data,
    output logic              busy
);
    localparam logic [IDX_W-1:0]  LAST     = IDX_W'(NCOEF - 1);
    localparam logic [ADDR_W-1:0] REG_BASE = ADDR_W'(1) << (ADDR_W - 1);
    localparam logic [ADDR_W-1:0] ADR_CTL  = REG_BASE;
    localparam logic [ADDR_W-1:0] ADR_PTR  = REG_BASE + ADDR_W'(4);
    localparam logic [ADDR_W-1:0] ADR_A0   = REG_BASE + ADDR_W'(8);
    localparam logic [ADDR_W-1:0] ADR_A1   = REG_BASE + ADDR_W'(12);
    localparam logic [ADDR_W-1:0] ADR_STAT = REG_BASE + ADDR_W'(16);
    localparam int LEN_LSB = 8;
    localparam int GO_BIT  = 31;

    typedef struct packed {
        logic             busy;
        vop_e             op;
        logic [IDX_W-1:0] len;
        logic [IDX_W-1:0] start;
        logic [IDX_W-1:0] idx;
        logic [IDX_W-1:0] cnt;
        logic [31:0]      a0;
        logic [31:0]      a1;
        logic             ov0;
        logic             ov1;
    } eng_t;

    eng_t s_q, s_d;

    logic [IDX_W-1:0] h_idx;
    logic st_hit, ctl_hit, ptr_hit, a0_hit, a1_hit, stat_hit;
    logic [1:0]  st_mask;
    logic [31:0] st_rdata, coef;
    logic [31:0] dp_nxt0, dp_nxt1;
    logic        dp_ov0, dp_ov1;
    logic        step;
    logic [IDX_W-1:0] wr_len, wr_start;
    vop_e        wr_op;
    logic [7:0]  status;

    // Address decode
    always_comb begin
        h_idx    = host_addr[ADDR_W-2:2];
        st_hit   = !host_addr[ADDR_W-1] && !host_addr[0] && (h_idx <= LAST);
        ctl_hit  = (host_addr == ADR_CTL);
        ptr_hit  = (host_addr == ADR_PTR);
        a0_hit   = (host_addr == ADR_A0);
        a1_hit   = (host_addr == ADR_A1);
        stat_hit = (host_addr == ADR_STAT);
        st_mask  = host_dword ? 2'b11 : (host_addr[1] ? 2'b10 : 2'b01);
    end

    vcm_cstore #(.NCOEF(NCOEF)) i_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (host_wr && st_hit),
        .wmask     (st_mask),
        .widx      (h_idx),
        .wdata     (host_wdata),
        .eng_idx   (s_q.idx),
        .eng_data  (coef),
        .host_idx  (h_idx),
        .host_data (st_rdata)
    );

    vcm_dp i_dp (
        .op   (s_q.op),
        .smp  (smp_data),
        .coef (coef),
        .acc0 (s_q.a0),
        .acc1 (s_q.a1),
        .nxt0 (dp_nxt0),
        .nxt1 (dp_nxt1),
        .ovf0 (dp_ov0),
        .ovf1 (dp_ov1)
    );

    // Next-state logic: engine step first, host writes take priority.
    always_comb begin
        s_d      = s_q;
        step     = s_q.busy && smp_valid;
        wr_op    = vop_e'(host_wdata[1:0]);
        wr_len   = host_wdata[LEN_LSB +: IDX_W];
        wr_start = (host_wdata[IDX_W-1:0] <= LAST) ? host_wdata[IDX_W-1:0] : '0;

        if (step) begin
            s_d.a0  = dp_nxt0;
            s_d.a1  = dp_nxt1;
            s_d.ov0 = s_q.ov0 | dp_ov0;
            s_d.ov1 = s_q.ov1 | dp_ov1;
            s_d.idx = (s_q.idx == LAST) ? '0 : s_q.idx + 1'b1;
            s_d.cnt = s_q.cnt - 1'b1;
            if (s_q.cnt == IDX_W'(1)) s_d.busy = 1'b0;
        end

        if (host_wr) begin
            if (ctl_hit) begin
                s_d.ov0 = 1'b0;
                s_d.ov1 = 1'b0;
                if (!s_q.busy) begin
                    s_d.op  = wr_op;
                    s_d.len = wr_len;
                    if (host_wdata[GO_BIT] && wr_len != '0) begin
                        s_d.busy = 1'b1;
                        s_d.idx  = s_q.start;
                        s_d.cnt  = wr_len;
                        if (wr_op == VOP_MAC) begin
                            s_d.a0 = '0;
                            s_d.a1 = '0;
                        end
                    end
                end
            end
            if (ptr_hit) s_d.start = wr_start;
            if (a0_hit) begin
                s_d.a0  = host_wdata;
                s_d.ov0 = 1'b0;
                s_d.ov1 = 1'b0;
            end
            if (a1_hit) begin
                s_d.a1  = host_wdata;
                s_d.ov0 = 1'b0;
                s_d.ov1 = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // Read mux
    always_comb begin
        status     = {s_q.ov0 | s_q.ov1, 5'b0, s_q.ov1, s_q.ov0};
        host_rdata = '0;
        if (st_hit) begin
            host_rdata = st_rdata;
        end else if (ctl_hit) begin
            host_rdata[1:0]              = s_q.op;
            host_rdata[LEN_LSB +: IDX_W] = s_q.len;
        end else if (ptr_hit) begin
            host_rdata[IDX_W-1:0] = s_q.start;
        end else if (a0_hit) begin
            host_rdata = s_q.a0;
        end else if (a1_hit) begin
            host_rdata = s_q.a1;
        end else if (stat_hit) begin
            host_rdata[7:0] = status;
        end
    end

    assign busy = s_q.busy;

    // Assertions
    assert_busy_end_R11: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.busy && smp_valid && s_q.cnt == IDX_W'(1) |=> !s_q.busy);

    assert_idx_wrap_R10: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.busy && smp_valid && s_q.idx == LAST |=> s_q.idx == '0);

    assert_ctl_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        host_wr && (ctl_hit || a0_hit || a1_hit) |=> !s_q.ov0 && !s_q.ov1);

    assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.ov0 && !(host_wr && (ctl_hit || a0_hit || a1_hit)) |=> s_q.ov0);

    assert_saturate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.busy && smp_valid && dp_ov0 && !(host_wr && a0_hit)
        |=> (s_q.a0 == 32'h7FFF_FFFF || s_q.a0 == 32'h8000_0000));

    assert_mag_keeps_a1_R6: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.busy && smp_valid && s_q.op == VOP_MAG && !(host_wr && a1_hit) |=> $stable(s_q.a1));

endmodule

// File: tb/test_vcm_engine.sv
`timescale 1ns/1ps
module test_vcm_engine;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0;
    logic        host_dword = 1'b0;
    logic [9:0]  host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        smp_valid = 1'b0;
    logic [31:0] smp_data = '0;
    logic        busy;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    vcm_engine i_vcm_engine (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_dword(host_dword),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .smp_valid(smp_valid), .smp_data(smp_data), .busy(busy)
    );

    // Behavioural reference model
    logic [31:0] m_mem [96];
    longint m_a0, m_a1;
    bit m_ov0, m_ov1, m_busy;
    int m_idx, m_cnt, m_op, m_len, m_start;

    function automatic longint s16(input logic [15:0] v);
        return longint'($signed(v));
    endfunction

    function automatic longint clampv(input longint v, inout bit ov);
        if (v > 64'sd2147483647) begin ov = 1'b1; return 64'sd2147483647; end
        if (v < -64'sd2147483648) begin ov = 1'b1; return -64'sd2147483648; end
        return v;
    endfunction

    function automatic logic [31:0] m_read(input int a);
        if (a < 384 && (a % 2) == 0) return m_mem[a / 4];
        case (a)
            512: return 32'(m_op) | (32'(m_len) << 8);
            516: return 32'(m_start);
            520: return 32'(m_a0);
            524: return 32'(m_a1);
            528: return {24'b0, m_ov0 | m_ov1, 5'b0, m_ov1, m_ov0};
            default: return 32'h0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (m_mem[i]) m_mem[i] = '0;
            m_a0 = 0; m_a1 = 0; m_ov0 = 0; m_ov1 = 0; m_busy = 0;
            m_idx = 0; m_cnt = 0; m_op = 0; m_len = 0; m_start = 0;
        end else begin
            if (m_busy && smp_valid) begin
                longint xr, xi, cr, ci, re, im, mg, n0, n1;
                xr = s16(smp_data[15:0]);  xi = s16(smp_data[31:16]);
                cr = s16(m_mem[m_idx][15:0]); ci = s16(m_mem[m_idx][31:16]);
                re = xr * cr - xi * ci;
                im = xr * ci + xi * cr;
                mg = xr * xr + xi * xi;
                case (m_op)
                    1: begin n0 = re; n1 = im; end
                    3: begin n0 = m_a0 + mg; n1 = m_a1; end
                    default: begin n0 = m_a0 + re; n1 = m_a1 + im; end
                endcase
                m_a0 = clampv(n0, m_ov0);
                m_a1 = clampv(n1, m_ov1);
                m_idx = (m_idx == 95) ? 0 : m_idx + 1;
                m_cnt--;
                if (m_cnt == 0) m_busy = 0;
            end
            if (host_wr) begin
                int a;
                a = int'(host_addr);
                if (a < 384 && (a % 2) == 0) begin
                    if (host_dword) m_mem[a / 4] = host_wdata;
                    else if (a % 4 == 2) m_mem[a / 4][31:16] = host_wdata[15:0];
                    else m_mem[a / 4][15:0] = host_wdata[15:0];
                end else if (a == 512) begin
                    m_ov0 = 0; m_ov1 = 0;
                    if (!m_busy) begin
                        m_op = int'(host_wdata[1:0]);
                        m_len = int'(host_wdata[14:8]);
                        if (host_wdata[31] && m_len != 0) begin
                            m_busy = 1; m_idx = m_start; m_cnt = m_len;
                            if (m_op == 2) begin m_a0 = 0; m_a1 = 0; end
                        end
                    end
                end else if (a == 516) begin
                    m_start = (host_wdata[6:0] <= 7'd95) ? int'(host_wdata[6:0]) : 0;
                end else if (a == 520) begin
                    m_a0 = longint'($signed(host_wdata)); m_ov0 = 0; m_ov1 = 0;
                end else if (a == 524) begin
                    m_a1 = longint'($signed(host_wdata)); m_ov0 = 0; m_ov1 = 0;
                end
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Comparison against the model on every clock
    always @(negedge clk) begin
        if (rst_n && !done) begin
            #1;
            chk(busy == m_busy, "R11 busy vs model", 32'(busy), 32'(m_busy));
            chk(host_rdata == m_read(int'(host_addr)), "R3 readback vs model",
                host_rdata, m_read(int'(host_addr)));
        end
    end

    task automatic hwr(input int a, input logic [31:0] d, input bit dw);
        @(negedge clk);
        host_wr = 1'b1; host_addr = 10'(a); host_wdata = d; host_dword = dw;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd_chk(input int a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        host_addr = 10'(a);
        #1;
        chk(host_rdata == exp, tag, host_rdata, exp);
    endtask

    task automatic smp(input logic [31:0] d);
        @(negedge clk);
        smp_valid = 1'b1; smp_data = d;
    endtask

    task automatic idle();
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd_chk(528, 32'h0, "R1 status");
        rd_chk(520, 32'h0, "R1 A0");
        rd_chk(0, 32'h0, "R1 C0");
        chk(busy == 1'b0, "R1 busy", 32'(busy), 32'h0);

        // R2 store addressing and 16-bit halves
        hwr(32'h17E, 32'h0000_1234, 1'b0);
        hwr(32'h17C, 32'h0000_ABCD, 1'b0);
        rd_chk(32'h17C, 32'h1234_ABCD, "R2 half writes");
        hwr(32'h178, 32'h0001_0002, 1'b1);
        hwr(32'h17C, 32'h0000_0003, 1'b1);
        hwr(32'h000, 32'hFFFF_0001, 1'b1);
        rd_chk(32'h17C, 32'h0000_0003, "R2 dword write");

        // R10 start clamp
        hwr(32'h204, 32'd100, 1'b1);
        rd_chk(32'h204, 32'h0, "R10 start above 95");
        hwr(32'h204, 32'd94, 1'b1);

        // R5 MAC with preload, wrap, stall
        hwr(32'h208, 32'd100, 1'b1);
        hwr(32'h200, 32'h8000_0302, 1'b1);
        chk(busy == 1'b1, "R11 busy after go", 32'(busy), 32'h1);
        smp(32'h0002_0001);
        smp(32'h0000_0002);
        idle();
        #1 chk(busy == 1'b1, "R11 busy during stall", 32'(busy), 32'h1);
        idle();
        smp(32'h0001_0004);
        idle();
        #1 chk(busy == 1'b0, "R11 busy falls", 32'(busy), 32'h0);
        rd_chk(32'h208, 32'd11, "R5 A0 clear and accumulate");
        rd_chk(32'h20C, 32'd2, "R10 A1 after wrap");

        // R3 multiply-add on current values
        hwr(32'h204, 32'd0, 1'b1);
        hwr(32'h200, 32'h8000_0100, 1'b1);
        smp(32'h0000_0003);
        idle();
        rd_chk(32'h208, 32'd14, "R3 A0");
        rd_chk(32'h20C, 32'hFFFF_FFFF, "R3 A1");

        // R4 multiply keeps last product
        hwr(32'h204, 32'd94, 1'b1);
        hwr(32'h200, 32'h8000_0201, 1'b1);
        smp(32'h0002_0001);
        smp(32'h0000_0002);
        idle();
        rd_chk(32'h208, 32'd6, "R4 A0");
        rd_chk(32'h20C, 32'd0, "R4 A1");

        // R6 magnitude
        hwr(32'h208, 32'd10, 1'b1);
        hwr(32'h20C, 32'd7, 1'b1);
        hwr(32'h204, 32'd0, 1'b1);
        hwr(32'h200, 32'h8000_0203, 1'b1);
        smp(32'h0004_0003);
        smp(32'h0001_0001);
        idle();
        rd_chk(32'h208, 32'd37, "R6 A0");
        rd_chk(32'h20C, 32'd7, "R6 A1 unchanged");

        // R7 positive saturation in magnitude, R9 clear by A1 write
        hwr(32'h208, 32'd0, 1'b1);
        hwr(32'h200, 32'h8000_0103, 1'b1);
        smp(32'h8000_8000);
        idle();
        rd_chk(32'h208, 32'h7FFF_FFFF, "R7 A0 saturates high");
        rd_chk(528, 32'h81, "R8 status A0 overflow");
        hwr(32'h20C, 32'd5, 1'b1);
        rd_chk(528, 32'h0, "R9 clear by A1 write");

        // R9 clear by control write without go
        hwr(32'h200, 32'h8000_0103, 1'b1);
        smp(32'h8000_8000);
        idle();
        rd_chk(528, 32'h81, "R7 overflow again");
        hwr(32'h200, 32'h0000_0103, 1'b1);
        rd_chk(528, 32'h0, "R9 clear by control write");
        chk(busy == 1'b0, "R11 no go bit", 32'(busy), 32'h0);

        // R9 clear by A0 write
        hwr(32'h200, 32'h8000_0103, 1'b1);
        smp(32'h8000_8000);
        idle();
        hwr(32'h208, 32'd1, 1'b1);
        rd_chk(528, 32'h0, "R9 clear by A0 write");

        // R7/R8 both accumulators saturate, flags stay set
        for (int i = 1; i <= 4; i++) hwr(4 * i, 32'h7FFF_7FFF, 1'b1);
        hwr(32'h204, 32'd1, 1'b1);
        hwr(32'h200, 32'h8000_0402, 1'b1);
        smp(32'h0000_7FFF);
        smp(32'h0000_7FFF);
        smp(32'h0000_7FFF);
        smp(32'h0000_8000);
        idle();
        rd_chk(32'h208, 32'h4000_7FFF, "R7 A0 after saturation");
        rd_chk(32'h20C, 32'h4000_7FFF, "R7 A1 after saturation");
        rd_chk(528, 32'h83, "R8 sticky flags");

        // R7 negative saturation
        hwr(32'h208, 32'h8000_0000, 1'b1);
        hwr(32'h20C, 32'h0, 1'b1);
        hwr(32'h204, 32'd1, 1'b1);
        hwr(32'h200, 32'h8000_0100, 1'b1);
        smp(32'h0000_FFFF);
        idle();
        rd_chk(32'h208, 32'h8000_0000, "R7 A0 saturates low");
        rd_chk(32'h20C, 32'hFFFF_8001, "R3 A1 negative");
        rd_chk(528, 32'h81, "R8 status low overflow");

        // R11 control write ignored while busy, zero length
        hwr(32'h17C, 32'h0000_0003, 1'b1);
        hwr(32'h204, 32'd94, 1'b1);
        hwr(32'h200, 32'h8000_0202, 1'b1);
        smp(32'h0002_0001);
        idle();
        hwr(32'h200, 32'h8000_0501, 1'b1);
        rd_chk(32'h200, 32'h0000_0202, "R11 control held while busy");
        smp(32'h0000_0002);
        idle();
        #1 chk(busy == 1'b0, "R11 run ends", 32'(busy), 32'h0);
        rd_chk(32'h208, 32'd6, "R11 A0 of original run");
        rd_chk(32'h20C, 32'd5, "R11 A1 of original run");
        hwr(32'h200, 32'h8000_0002, 1'b1);
        #1 chk(busy == 1'b0, "R11 zero length", 32'(busy), 32'h0);

        repeat (3) @(negedge clk);
        done = 1'b1;
        summary();
        $finish;
    end

endmodule